// File: doc/BRIEF.md
# Factory Bad-Block Table Builder

This block runs by itself once each reset ends. It walks every erase block of a NAND array in ascending order and, for each one, asks a lower read layer for a single marker byte in the block's first page and then in its second page. Erased cells read FFh. The factory writes 00h at the marker position of a defective block. Any value other than FFh, or a read that the lower layer reports as failed, marks the block unusable. The results go into an internal table with one bit per block.

Block 0 is written as usable without being read. When the walk ends, the block raises a done flag. It then offers the number of usable blocks, a warning when that number is below the guaranteed minimum, a sticky flag that records any read failure, and a registered lookup port. An address-mapping layer uses that port to skip unusable blocks. The builder issues reads only, so the factory markers are never disturbed.

Top module: `bad_block_scan`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `scan_done`, `valid_count`, `low_warn`, `read_err` and `tbl_bit` are 0. The walk then starts with no further input. Each reset starts a fresh walk.
- R2: Requests come in ascending block order. Within a block, page 0 is read before page 1. Every request has `req_col` equal to `MARK_COL` (default 0) and `req_page` of 0 or 1. No other page is ever requested.
- R3: `req_valid` stays high with a stable address until the cycle in which `rsp_valid` is high. Only one read is outstanding at a time. No request is made once `scan_done` is high.
- R4: A block other than block 0 is marked usable (table bit 1) only if both marker bytes read FFh. The factory value 00h, or any other non-FFh value, in either page marks it unusable (table bit 0).
- R5: If the page-0 byte already fails, page 1 of that block is not requested. A block therefore costs one read when it fails on page 0 and two reads otherwise.
- R6: Block 0 is never read and its table bit is always 1.
- R7: A response with `rsp_err` high marks that block unusable. It also sets `read_err`, which stays high until reset.
- R8: After `scan_done`, `valid_count` equals the number of 1 bits in the table and does not change. It never decreases during the walk.
- R9: `low_warn` is high exactly when `scan_done` is high and `valid_count` is below `MIN_VALID` (default 502). A count of 502 does not warn and a count of 501 does.
- R10: `tbl_bit` shows the table bit of block `tbl_idx` one clock after the index is presented. It reads 0 while `scan_done` is low.
- R11: `scan_done` rises after the last block's bit is written and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | output | 1 | Read request pending |
| req_block | output | BLK_W (9) | Block index of the request |
| req_page | output | PG_W (4) | Page within the block (0 or 1) |
| req_col | output | COL_W (9) | Byte column of the marker |
| rsp_valid | input | 1 | One-cycle response strobe from the read layer |
| rsp_data | input | 8 | Byte read at the requested address |
| rsp_err | input | 1 | Read layer reports a failed read |
| scan_done | output | 1 | Table complete |
| valid_count | output | CNT_W (10) | Number of usable blocks |
| low_warn | output | 1 | Usable count below MIN_VALID after done |
| read_err | output | 1 | Sticky: some read failed |
| tbl_idx | input | BLK_W (9) | Block index for table lookup |
| tbl_bit | output | 1 | Registered lookup result, 1 = usable |

## Verification
A wrong verdict register or a missed clear between blocks shows up as a wrong table bit, seen in the post-done sweep of all blocks. It also moves `valid_count` by one at the moment `scan_done` rises. A broken page sequence shows at the request port in the very cycle after a response: an extra read, a skipped block or an out-of-order address, each caught by the bench's running request tally and by the order properties. A lost error flag is visible at `read_err` in the cycle after the failing response, and the final check catches it as well.

// File: rtl/bbt_pkg.sv
package bbt_pkg;

    localparam int unsigned BBT_BLOCKS_DEF     = 512;
    localparam int unsigned BBT_PAGES_DEF      = 16;
    localparam int unsigned BBT_PAGE_BYTES_DEF = 512;
    localparam int unsigned BBT_MIN_VALID_DEF  = 502;
    localparam logic [7:0]  BBT_ERASED         = 8'hFF;

    typedef enum logic [2:0] {
        SC_SEED,
        SC_PAGE0,
        SC_PAGE1,
        SC_COMMIT,
        SC_DONE
    } scan_state_e;

    // verdict on a single marker read
    typedef struct packed {
        logic fail;
        logic rd_err;
    } probe_result_t;

    // one table write
    typedef struct packed {
        logic en;
        logic val;
    } tbl_write_t;

    function automatic probe_result_t judge_marker(input logic [7:0] data,
                                                   input logic       err);
        probe_result_t r;
        r.rd_err = err;
        r.fail   = err || (data != BBT_ERASED);
        return r;
    endfunction

endpackage

// File: rtl/bbt_scan_fsm.sv
module bbt_scan_fsm
    import bbt_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS = BBT_BLOCKS_DEF,
    parameter int unsigned MARK_COL   = 0,
    parameter int unsigned BLK_W      = 9,
    parameter int unsigned PG_W       = 4,
    parameter int unsigned COL_W      = 9
) (
    input  logic             clk,
    input  logic             rst,
    output logic             req_valid,
    output logic [BLK_W-1:0] req_block,
    output logic [PG_W-1:0]  req_page,
    output logic [COL_W-1:0] req_col,
    input  logic             rsp_valid,
    input  logic [7:0]       rsp_data,
    input  logic             rsp_err,
    output tbl_write_t       wr,
    output logic [BLK_W-1:0] wr_idx,
    output logic             done,
    output logic             read_err
);

    localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);

    scan_state_e      state;
    logic [BLK_W-1:0] blk;
    logic             bad;
    logic             err_q;
    probe_result_t    res;

    assign res       = judge_marker(rsp_data, rsp_err);
    assign req_block = blk;
    assign req_col   = COL_W'(MARK_COL);
    assign done      = (state == SC_DONE);
    assign read_err  = err_q;

    always_comb begin
        req_valid = 1'b0;
        req_page  = '0;
        wr        = '0;
        wr_idx    = blk;
        case (state)
            SC_SEED: begin
                wr.en  = 1'b1;
                wr.val = 1'b1;
                wr_idx = '0;
            end
            SC_PAGE0: req_valid = 1'b1;
            SC_PAGE1: begin
                req_valid = 1'b1;
                req_page  = PG_W'(1);
            end
            SC_COMMIT: begin
                wr.en  = 1'b1;
                wr.val = !bad;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SC_SEED;
            blk   <= '0;
            bad   <= 1'b0;
            err_q <= 1'b0;
        end else begin
            case (state)
                SC_SEED: begin
                    blk   <= BLK_W'(1);
                    state <= SC_PAGE0;
                end
                SC_PAGE0: begin
                    if (rsp_valid) begin
                        if (res.rd_err) err_q <= 1'b1;
                        if (res.fail) begin
                            bad   <= 1'b1;
                            state <= SC_COMMIT;
                        end else begin
                            state <= SC_PAGE1;
                        end
                    end
                end
                SC_PAGE1: begin
                    if (rsp_valid) begin
                        if (res.rd_err) err_q <= 1'b1;
                        bad   <= res.fail;
                        state <= SC_COMMIT;
                    end
                end
                SC_COMMIT: begin
                    bad <= 1'b0;
                    if (blk == LAST_BLK) begin
                        state <= SC_DONE;
                    end else begin
                        blk   <= blk + BLK_W'(1);
                        state <= SC_PAGE0;
                    end
                end
                default: state <= SC_DONE;
            endcase
        end
    end

endmodule

// File: rtl/bbt_valid_table.sv
module bbt_valid_table
    import bbt_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS = BBT_BLOCKS_DEF,
    parameter int unsigned BLK_W      = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  tbl_write_t       wr,
    input  logic [BLK_W-1:0] wr_idx,
    input  logic             rd_en,
    input  logic [BLK_W-1:0] rd_idx,
    output logic             rd_bit
);

    logic [NUM_BLOCKS-1:0] bits;
    logic                  in_range;

    assign in_range = (32'(rd_idx) < NUM_BLOCKS);

    always_ff @(posedge clk) begin
        if (rst) begin
            bits <= '0;
        end else if (wr.en) begin
            bits[wr_idx] <= wr.val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_bit <= 1'b0;
        end else begin
            rd_bit <= rd_en && in_range && bits[rd_idx];
        end
    end

endmodule

// File: rtl/bbt_tally.sv
module bbt_tally
    import bbt_pkg::*;
#(
    parameter int unsigned MIN_VALID = BBT_MIN_VALID_DEF,
    parameter int unsigned CNT_W     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  tbl_write_t       wr,
    input  logic             done,
    output logic [CNT_W-1:0] count,
    output logic             warn
);

    localparam logic [CNT_W-1:0] FLOOR = CNT_W'(MIN_VALID);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (wr.en && wr.val) begin
            count <= count + CNT_W'(1);
        end
    end

    assign warn = done && (count < FLOOR);

endmodule

// File: rtl/bad_block_scan.sv
module bad_block_scan
    import bbt_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS      = BBT_BLOCKS_DEF,
    parameter int unsigned PAGES_PER_BLOCK = BBT_PAGES_DEF,
    parameter int unsigned PAGE_BYTES      = BBT_PAGE_BYTES_DEF,
    parameter int unsigned MARK_COL        = 0,
    parameter int unsigned MIN_VALID       = BBT_MIN_VALID_DEF,
    localparam int unsigned BLK_W          = $clog2(NUM_BLOCKS),
    localparam int unsigned PG_W           = $clog2(PAGES_PER_BLOCK),
    localparam int unsigned COL_W          = $clog2(PAGE_BYTES),
    localparam int unsigned CNT_W          = $clog2(NUM_BLOCKS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    output logic             req_valid,
    output logic [BLK_W-1:0] req_block,
    output logic [PG_W-1:0]  req_page,
    output logic [COL_W-1:0] req_col,
    input  logic             rsp_valid,
    input  logic [7:0]       rsp_data,
    input  logic             rsp_err,
    output logic             scan_done,
    output logic [CNT_W-1:0] valid_count,
    output logic             low_warn,
    output logic             read_err,
    input  logic [BLK_W-1:0] tbl_idx,
    output logic             tbl_bit
);

    tbl_write_t       wr;
    logic [BLK_W-1:0] wr_idx;

    bbt_scan_fsm #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .MARK_COL  (MARK_COL),
        .BLK_W     (BLK_W),
        .PG_W      (PG_W),
        .COL_W     (COL_W)
    ) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .req_valid(req_valid),
        .req_block(req_block),
        .req_page (req_page),
        .req_col  (req_col),
        .rsp_valid(rsp_valid),
        .rsp_data (rsp_data),
        .rsp_err  (rsp_err),
        .wr       (wr),
        .wr_idx   (wr_idx),
        .done     (scan_done),
        .read_err (read_err)
    );

    bbt_valid_table #(
        .NUM_BLOCKS(NUM_BLOCKS),
        .BLK_W     (BLK_W)
    ) u_table (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .wr_idx(wr_idx),
        .rd_en (scan_done),
        .rd_idx(tbl_idx),
        .rd_bit(tbl_bit)
    );

    bbt_tally #(
        .MIN_VALID(MIN_VALID),
        .CNT_W    (CNT_W)
    ) u_tally (
        .clk  (clk),
        .rst  (rst),
        .wr   (wr),
        .done (scan_done),
        .count(valid_count),
        .warn (low_warn)
    );

endmodule

// File: rtl/bbt_checker.sv
module bbt_checker #(
    parameter int unsigned BLK_W    = 9,
    parameter int unsigned PG_W     = 4,
    parameter int unsigned COL_W    = 9,
    parameter int unsigned CNT_W    = 10,
    parameter int unsigned MARK_COL = 0
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [BLK_W-1:0] req_block,
    input logic [PG_W-1:0]  req_page,
    input logic [COL_W-1:0] req_col,
    input logic             rsp_valid,
    input logic             scan_done,
    input logic [CNT_W-1:0] valid_count,
    input logic             low_warn,
    input logic             read_err
);

    p_req_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !rsp_valid) |=>
            (req_valid && $stable(req_block) && $stable(req_page)));

    p_idle_after_done_r3: assert property (@(posedge clk) disable iff (rst)
        scan_done |-> !req_valid);

    p_marker_addr_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_col == COL_W'(MARK_COL) && req_page <= PG_W'(1)));

    p_ascending_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && rsp_valid) |=>
            (!req_valid || req_block > $past(req_block) ||
             (req_block == $past(req_block) && req_page > $past(req_page))));

    p_seed_unread_r6: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> (req_block != '0));

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        read_err |=> read_err);

    p_count_mono_r8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (valid_count >= $past(valid_count)));

    p_count_frozen_r8: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> $stable(valid_count));

    p_warn_gated_r9: assert property (@(posedge clk) disable iff (rst)
        low_warn |-> scan_done);

    p_done_sticky_r11: assert property (@(posedge clk) disable iff (rst)
        scan_done |=> scan_done);

endmodule

bind bad_block_scan bbt_checker #(
    .BLK_W   (BLK_W),
    .PG_W    (PG_W),
    .COL_W   (COL_W),
    .CNT_W   (CNT_W),
    .MARK_COL(MARK_COL)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_block  (req_block),
    .req_page   (req_page),
    .req_col    (req_col),
    .rsp_valid  (rsp_valid),
    .scan_done  (scan_done),
    .valid_count(valid_count),
    .low_warn   (low_warn),
    .read_err   (read_err)
);

// File: tb/bad_block_scan_tb.sv
`timescale 1ns/1ps
module bad_block_scan_tb;

    localparam int NB = 512;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid;
    logic [8:0] req_block;
    logic [3:0] req_page;
    logic [8:0] req_col;
    logic       rsp_valid;
    logic [7:0] rsp_data;
    logic       rsp_err;
    logic       scan_done;
    logic [9:0] valid_count;
    logic       low_warn;
    logic       read_err;
    logic [8:0] tbl_idx = '0;
    logic       tbl_bit;

    int checks = 0;
    int fails  = 0;
    int scen   = 0;

    // read-layer model state
    logic busy;
    int   wait_cnt;
    int   cap_blk, cap_pg;
    int   n_reads, order_bad, col_bad, seed_reads;
    int   last_blk, last_pg;
    logic have_last;

    always #2.5 clk = ~clk;

    bad_block_scan u_dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_block(req_block), .req_page(req_page),
        .req_col(req_col), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_err(rsp_err), .scan_done(scan_done), .valid_count(valid_count),
        .low_warn(low_warn), .read_err(read_err), .tbl_idx(tbl_idx),
        .tbl_bit(tbl_bit)
    );

    // marker byte per scenario; 00h is the factory mark, FFh erased
    function automatic logic [7:0] mark_byte(int sc, int b, int p);
        case (sc)
            0: begin
                if (p == 0 && (b == 0 || b == 3 || b == 100 || b == 511)) return 8'h00;
                if (p == 1 && (b == 7 || b == 300)) return 8'h00;
                if (p == 0 && b == 200) return 8'h7F;
                return 8'hFF;
            end
            1: begin
                if (p == 1 && (b % 8) == 1) return 8'h00;
                if (p == 1 && b == 2) return 8'hFE;
                return 8'hFF;
            end
            3: return (p == 0 && b >= 10 && b <= 19) ? 8'h00 : 8'hFF;
            4: return (p == 0 && b >= 10 && b <= 20) ? 8'h00 : 8'hFF;
            default: return 8'hFF;
        endcase
    endfunction

    function automatic bit mark_err(int sc, int b, int p);
        return (sc == 0) && ((b == 411 && p == 1) || (b == 450 && p == 0));
    endfunction

    function automatic bit exp_valid(int sc, int b);
        if (b == 0) return 1'b1;
        if (mark_err(sc, b, 0) || mark_byte(sc, b, 0) != 8'hFF) return 1'b0;
        return !(mark_err(sc, b, 1) || mark_byte(sc, b, 1) != 8'hFF);
    endfunction

    function automatic int exp_reads_of(int sc, int b);
        if (b == 0) return 0;
        if (mark_err(sc, b, 0) || mark_byte(sc, b, 0) != 8'hFF) return 1;
        return 2;
    endfunction

    // read-layer model: one outstanding read, latency varies by block
    always @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0; rsp_valid <= 1'b0; rsp_data <= 8'h00; rsp_err <= 1'b0;
            n_reads <= 0; order_bad <= 0; col_bad <= 0; seed_reads <= 0;
            have_last <= 1'b0; last_blk <= 0; last_pg <= 0;
        end else begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            if (busy) begin
                if (wait_cnt == 0) begin
                    rsp_valid <= 1'b1;
                    rsp_data  <= mark_byte(scen, cap_blk, cap_pg);
                    rsp_err   <= mark_err(scen, cap_blk, cap_pg);
                    busy      <= 1'b0;
                end else begin
                    wait_cnt <= wait_cnt - 1;
                end
            end else if (req_valid && !rsp_valid) begin
                busy     <= 1'b1;
                cap_blk  <= int'(req_block);
                cap_pg   <= int'(req_page);
                wait_cnt <= int'(req_block) % 3;
                n_reads  <= n_reads + 1;
                if (req_col != 9'd0) col_bad <= col_bad + 1;
                if (req_block == 9'd0) seed_reads <= seed_reads + 1;
                if (have_last && !(int'(req_block) > last_blk ||
                    (int'(req_block) == last_blk && int'(req_page) > last_pg)))
                    order_bad <= order_bad + 1;
                have_last <= 1'b1;
                last_blk  <= int'(req_block);
                last_pg   <= int'(req_page);
            end
        end
    end

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // probe vectors for scenario 0: {block, expected table bit}
    localparam logic [9:0] PROBES [0:11] = '{
        {9'd0,   1'b1}, {9'd1,   1'b1}, {9'd2,   1'b1}, {9'd3,   1'b0},
        {9'd7,   1'b0}, {9'd100, 1'b0}, {9'd200, 1'b0}, {9'd300, 1'b0},
        {9'd410, 1'b1}, {9'd411, 1'b0}, {9'd450, 1'b0}, {9'd511, 1'b0}
    };

    task automatic run_scan(int sc);
        int exp_cnt = 0;
        int exp_rd  = 0;
        int exp_e   = 0;
        int mism    = 0;
        int held_rd;
        int held_cnt;
        int guard   = 0;
        scen = sc;
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 done in reset", int'(scan_done), 0);
        check("R1 count in reset", int'(valid_count), 0);
        check("R1 flags in reset", int'(low_warn) + int'(read_err) + int'(tbl_bit), 0);
        rst = 1'b0;
        tbl_idx = 9'd0;
        @(negedge clk);
        @(negedge clk);
        // R10: lookup blocked before done (block 0 bit is already written)
        check("R10 lookup before done", int'(tbl_bit), 0);
        check("R1 walk started", int'(scan_done), 0);
        while (!scan_done && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        check("R11 done reached", int'(scan_done), 1);
        for (int b = 0; b < NB; b++) begin
            exp_cnt += int'(exp_valid(sc, b));
            exp_rd  += exp_reads_of(sc, b);
            if (b != 0 && (mark_err(sc, b, 0) ||
                (mark_byte(sc, b, 0) == 8'hFF && mark_err(sc, b, 1)))) exp_e = 1;
        end
        check("R8 valid count", int'(valid_count), exp_cnt);
        check("R9 low warn", int'(low_warn), int'(exp_cnt < 502));
        check("R7 read error flag", int'(read_err), exp_e);
        check("R5 read count", n_reads, exp_rd);
        check("R2 ascending order", order_bad, 0);
        check("R2 marker column", col_bad, 0);
        check("R6 block0 unread", seed_reads, 0);
        if (sc == 0) begin
            for (int i = 0; i < 12; i++) begin
                tbl_idx = PROBES[i][9:1];
                @(negedge clk);
                check($sformatf("R4 probe block %0d", int'(PROBES[i][9:1])),
                      int'(tbl_bit), int'(PROBES[i][0]));
            end
        end
        for (int b = 0; b < NB; b++) begin
            tbl_idx = 9'(b);
            @(negedge clk);
            if (tbl_bit != exp_valid(sc, b)) mism++;
        end
        check("R4 R10 table sweep mismatches", mism, 0);
        held_rd  = n_reads;
        held_cnt = int'(valid_count);
        repeat (20) @(negedge clk);
        check("R11 done held", int'(scan_done), 1);
        check("R8 count frozen", int'(valid_count), held_cnt);
        check("R3 no reads after done", n_reads, held_rd);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        run_scan(0);   // mixed markers, read errors, block 0 marked
        run_scan(1);   // many page-1 marks, warn expected
        run_scan(2);   // all erased, 512 usable
        run_scan(3);   // exactly 502 usable: no warn (R9)
        run_scan(4);   // 501 usable: warn (R9)
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule